// File: doc/BRIEF.md
# AXI4-Lite to APB Bridge with Protection Forwarding

This block sits between a single AXI4-Lite subordinate port and an APB requester port driving one completer. It takes one read or one write at a time, runs the two-phase APB transfer (a setup cycle, then an access phase that lasts until the completer raises its ready), and returns the outcome on the matching AXI response channel. A completer error becomes an AXI SLVERR response.

The bridge carries the security context of each access across. The 3-bit protection field of the channel that won the grant (read-address for a read, write-address for a write) is forwarded bit for bit to the APB protection bus. An optional fourth "world extension" bit, which together with the secure/non-secure bit picks one of four address spaces, travels the same way. When the upstream side has no such bit (parameter `WORLD_EXT` = 0), the APB extension output is held low. Address, protection, extension bit and write data are captured at the AXI handshake, so upstream may change them while the APB transfer is still in progress.

When a read and a complete write (address and data both valid) are waiting together in the idle state, the read is served first and the winner alternates on every later collision.

Top module: `apbb_top`

## Requirements
- R1: During a transfer `m_pprot[i]` equals bit i of the protection field of the granted channel, for i = 0, 1, 2: `s_arprot` for a read, `s_awprot` for a write; the other channel's field has no effect.
- R2: In the first cycle after the AXI handshake `m_psel` is 1 and `m_penable` is 0, with `m_paddr`, `m_pwrite` (1 = write), `m_pprot`, `m_pnse` and, for writes, `m_pwdata` already carrying the captured request.
- R3: If `m_pslverr` is 1 in the cycle `m_pready` ends the transfer, the AXI response is 2'b10 (SLVERR); otherwise it is 2'b00 (OKAY). A read returns the `m_prdata` value sampled in that cycle on `s_rdata`.
- R4: `m_paddr`, `m_pprot`, `m_pnse` and `m_pwdata` hold their values through every wait cycle with `m_pready` low, even while the AXI request inputs change.
- R5: `m_penable` rises exactly one cycle after `m_psel` rises; both are low in the cycle after `m_pready` is sampled high in the access phase.
- R6: A write is accepted only when `s_awvalid` and `s_wvalid` are both high; at most one channel is accepted at a time and none while a transfer or response is outstanding; on a read/write collision in idle the read wins first and the winner alternates on each later collision.
- R7: `s_bvalid`/`s_rvalid` and the response code stay unchanged until `s_bready`/`s_rready` is high, and drop in the cycle after acceptance.
- R8: With `WORLD_EXT` = 1, `m_pnse` equals the world bit of the granted channel (`s_arworld` or `s_awworld`); with `WORLD_EXT` = 0 it is 0.
- R9: After reset `m_psel`, `m_penable`, `s_bvalid`, `s_rvalid`, `s_arready`, `s_awready` and `s_wready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_awaddr | input | ADDR_W | Write address |
| s_awprot | input | 3 | Write protection attributes |
| s_awworld | input | 1 | Write world-extension bit |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response accepted |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_araddr | input | ADDR_W | Read address |
| s_arprot | input | 3 | Read protection attributes |
| s_arworld | input | 1 | Read world-extension bit |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data accepted |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| m_psel | output | 1 | Completer select |
| m_penable | output | 1 | Access phase marker |
| m_pwrite | output | 1 | Transfer direction, 1 = write |
| m_paddr | output | ADDR_W | Transfer address |
| m_pwdata | output | DATA_W | Transfer write data |
| m_pstrb | output | DATA_W/8 | Transfer byte strobes (0 on reads) |
| m_pprot | output | 3 | Transfer protection attributes |
| m_pnse | output | 1 | Transfer world-extension bit |
| m_pready | input | 1 | Completer ready |
| m_prdata | input | DATA_W | Completer read data |
| m_pslverr | input | 1 | Completer error |

## Verification
The bench drives the unused channel's protection and world inputs with the complement of the granted ones, so a bridge that routed the wrong channel, or swapped or inverted bits, shows a wrong `m_pprot`/`m_pnse` in setup. It scrambles every AXI request input right after the handshake and holds the completer in wait states, catching a bridge that forwards live inputs instead of captured ones. Back-to-back collisions check that the read wins first and the write wins the next one; a fixed-priority arbiter would hand the second collision to the read again. Responses are left unaccepted for a cycle to catch a bridge that drops valid early, and an error completion on both directions checks that the error maps to 2'b10 and not to a reserved code.

// File: rtl/apbb_pkg.sv
package apbb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2,
    ST_RESP   = 2'd3
  } apbb_state_e;

  localparam int          PROT_W      = 3;
  localparam int          RESP_W      = 2;
  localparam logic [1:0]  RESP_OKAY   = 2'b00;
  localparam logic [1:0]  RESP_SLVERR = 2'b10;

endpackage

// File: rtl/apbb_arbiter.sv
module apbb_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic rd_req,
  input  logic wr_req,
  output logic gnt_rd,
  output logic gnt_wr
);

  logic prefer_wr_q;
  logic prefer_wr_d;
  logic conflict;
  logic prefer_en;

  // Collision only counts when the bridge can take a request now.
  always_comb begin
    conflict    = idle & rd_req & wr_req;
    gnt_rd      = idle & rd_req & ~(wr_req &  prefer_wr_q);
    gnt_wr      = idle & wr_req & ~(rd_req & ~prefer_wr_q);
    prefer_en   = conflict;
    prefer_wr_d = ~prefer_wr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prefer_wr_q <= 1'b0;
    end else if (prefer_en) begin
      prefer_wr_q <= prefer_wr_d;
    end
  end

endmodule

// File: rtl/apbb_req_latch.sv
module apbb_req_latch #(
  parameter int   ADDR_W    = 16,
  parameter int   DATA_W    = 32,
  parameter bit   WORLD_EXT = 1'b1,
  localparam int  STRB_W    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              sel_wr,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic [2:0]        aw_prot,
  input  logic              aw_world,
  input  logic [ADDR_W-1:0] ar_addr,
  input  logic [2:0]        ar_prot,
  input  logic              ar_world,
  input  logic [DATA_W-1:0] w_data,
  input  logic [STRB_W-1:0] w_strb,
  output logic              q_write,
  output logic [ADDR_W-1:0] q_addr,
  output logic [2:0]        q_prot,
  output logic              q_world,
  output logic [DATA_W-1:0] q_data,
  output logic [STRB_W-1:0] q_strb
);

  logic [ADDR_W-1:0] addr_d;
  logic [2:0]        prot_d;
  logic [STRB_W-1:0] strb_d;

  // Protection bits are copied one to one from the granted channel.
  always_comb begin
    addr_d = sel_wr ? aw_addr : ar_addr;
    prot_d = sel_wr ? aw_prot : ar_prot;
    strb_d = sel_wr ? w_strb  : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_write <= 1'b0;
      q_addr  <= '0;
      q_prot  <= '0;
      q_data  <= '0;
      q_strb  <= '0;
    end else if (load) begin
      q_write <= sel_wr;
      q_addr  <= addr_d;
      q_prot  <= prot_d;
      q_data  <= w_data;
      q_strb  <= strb_d;
    end
  end

  generate
    if (WORLD_EXT) begin : g_world
      logic world_d;
      always_comb world_d = sel_wr ? aw_world : ar_world;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_world <= 1'b0;
        end else if (load) begin
          q_world <= world_d;
        end
      end
    end else begin : g_no_world
      // Upstream has no extension bit: drive the secure/non-secure pair only.
      always_comb q_world = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/apbb_apb_fsm.sv
module apbb_apb_fsm
  import apbb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_write,
  input  logic              pready,
  input  logic              pslverr,
  input  logic [DATA_W-1:0] prdata,
  input  logic              bready,
  input  logic              rready,
  output logic              idle,
  output logic              psel,
  output logic              penable,
  output logic              bvalid,
  output logic              rvalid,
  output logic [1:0]        resp,
  output logic [DATA_W-1:0] rdata
);

  apbb_state_e      state_q;
  apbb_state_e      state_d;
  logic             done;
  logic             resp_taken;
  logic             resp_en;
  logic             rdata_en;
  logic [1:0]       resp_d;

  always_comb begin
    done       = (state_q == ST_ACCESS) & pready;
    resp_taken = is_write ? bready : rready;
    resp_en    = done;
    rdata_en   = done & ~is_write;
    resp_d     = pslverr ? RESP_SLVERR : RESP_OKAY;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start)      state_d = ST_SETUP;
      ST_SETUP:                  state_d = ST_ACCESS;
      ST_ACCESS: if (pready)     state_d = ST_RESP;
      ST_RESP:   if (resp_taken) state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp <= RESP_OKAY;
    end else if (resp_en) begin
      resp <= resp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rdata_en) begin
      rdata <= prdata;
    end
  end

  always_comb begin
    idle    = (state_q == ST_IDLE);
    psel    = (state_q == ST_SETUP) | (state_q == ST_ACCESS);
    penable = (state_q == ST_ACCESS);
    bvalid  = (state_q == ST_RESP) &  is_write;
    rvalid  = (state_q == ST_RESP) & ~is_write;
  end

  AST_SETUP_THEN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable) |=> (psel && penable)); // R5

  AST_END_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pready) |=> (!psel && !penable)); // R5

  AST_ERR_TO_SLVERR: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pready && pslverr) |=> (resp == RESP_SLVERR)); // R3

  AST_RESP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((bvalid && !bready) || (rvalid && !rready)) |=> ((bvalid || rvalid) && $stable(resp) && $stable(rdata))); // R7

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> !start); // R6

endmodule

// File: rtl/apbb_top.sv
module apbb_top
  import apbb_pkg::*;
#(
  parameter int  ADDR_W    = 16,
  parameter int  DATA_W    = 32,
  parameter bit  WORLD_EXT = 1'b1,
  localparam int STRB_W    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic [2:0]        s_awprot,
  input  logic              s_awworld,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [1:0]        s_bresp,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic [2:0]        s_arprot,
  input  logic              s_arworld,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              m_psel,
  output logic              m_penable,
  output logic              m_pwrite,
  output logic [ADDR_W-1:0] m_paddr,
  output logic [DATA_W-1:0] m_pwdata,
  output logic [STRB_W-1:0] m_pstrb,
  output logic [2:0]        m_pprot,
  output logic              m_pnse,
  input  logic              m_pready,
  input  logic [DATA_W-1:0] m_prdata,
  input  logic              m_pslverr
);

  logic       idle;
  logic       gnt_rd;
  logic       gnt_wr;
  logic       start;
  logic [1:0] resp;

  always_comb begin
    start     = gnt_rd | gnt_wr;
    s_arready = gnt_rd;
    s_awready = gnt_wr;
    s_wready  = gnt_wr;
    s_bresp   = resp;
    s_rresp   = resp;
  end

  apbb_arbiter u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .idle   (idle),
    .rd_req (s_arvalid),
    .wr_req (s_awvalid & s_wvalid),
    .gnt_rd (gnt_rd),
    .gnt_wr (gnt_wr)
  );

  apbb_req_latch #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .WORLD_EXT (WORLD_EXT)
  ) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .sel_wr   (gnt_wr),
    .aw_addr  (s_awaddr),
    .aw_prot  (s_awprot),
    .aw_world (s_awworld),
    .ar_addr  (s_araddr),
    .ar_prot  (s_arprot),
    .ar_world (s_arworld),
    .w_data   (s_wdata),
    .w_strb   (s_wstrb),
    .q_write  (m_pwrite),
    .q_addr   (m_paddr),
    .q_prot   (m_pprot),
    .q_world  (m_pnse),
    .q_data   (m_pwdata),
    .q_strb   (m_pstrb)
  );

  apbb_apb_fsm #(
    .DATA_W (DATA_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .is_write (m_pwrite),
    .pready   (m_pready),
    .pslverr  (m_pslverr),
    .prdata   (m_prdata),
    .bready   (s_bready),
    .rready   (s_rready),
    .idle     (idle),
    .psel     (m_psel),
    .penable  (m_penable),
    .bvalid   (s_bvalid),
    .rvalid   (s_rvalid),
    .resp     (resp),
    .rdata    (s_rdata)
  );

  AST_PROT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_psel && m_penable && !m_pready) |=> ($stable(m_pprot) && $stable(m_pnse) && $stable(m_paddr) && $stable(m_pwdata))); // R4

  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_arready && s_awready)); // R6

  AST_WRITE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    s_awready |-> (s_awvalid && s_wvalid)); // R6

endmodule

// File: tb/apbb_top_bench.sv
`timescale 1ns/1ps
module apbb_top_bench;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int SW = DW / 8;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [2:0]    prot;
    logic          world;
    logic [DW-1:0] data;
    logic [3:0]    waits;
    logic          err;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{wr:1'b1, addr:16'h0010, prot:3'b011, world:1'b0, data:32'hA5A5_0001, waits:4'd0, err:1'b0},
    '{wr:1'b0, addr:16'h0F04, prot:3'b000, world:1'b1, data:32'h1234_5678, waits:4'd2, err:1'b0},
    '{wr:1'b1, addr:16'h0F08, prot:3'b110, world:1'b1, data:32'hDEAD_BEEF, waits:4'd3, err:1'b1},
    '{wr:1'b0, addr:16'h0020, prot:3'b101, world:1'b0, data:32'h0BAD_F00D, waits:4'd1, err:1'b1},
    '{wr:1'b1, addr:16'hFFFC, prot:3'b111, world:1'b0, data:32'h0000_0000, waits:4'd0, err:1'b0},
    '{wr:1'b0, addr:16'h0000, prot:3'b010, world:1'b1, data:32'hFFFF_FFFF, waits:4'd4, err:1'b0}
  };

  logic clk;
  logic rst_n;
  logic s_awvalid, s_awready, s_awworld, s_wvalid, s_wready, s_bvalid, s_bready;
  logic [AW-1:0] s_awaddr, s_araddr, m_paddr;
  logic [2:0] s_awprot, s_arprot, m_pprot;
  logic [DW-1:0] s_wdata, s_rdata, m_pwdata, m_prdata;
  logic [SW-1:0] s_wstrb, m_pstrb;
  logic [1:0] s_bresp, s_rresp;
  logic s_arvalid, s_arready, s_arworld, s_rvalid, s_rready;
  logic m_psel, m_penable, m_pwrite, m_pnse, m_pready, m_pslverr;

  logic n_awready, n_wready, n_bvalid, n_arready, n_rvalid;
  logic [1:0] n_bresp, n_rresp;
  logic [DW-1:0] n_rdata, n_pwdata;
  logic [AW-1:0] n_paddr;
  logic [2:0] n_pprot;
  logic [SW-1:0] n_pstrb;
  logic n_psel, n_penable, n_pwrite, n_pnse;

  int total;
  int bad;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  apbb_top #(.ADDR_W(AW), .DATA_W(DW), .WORLD_EXT(1'b1)) u_apbb_top (
    .clk(clk), .rst_n(rst_n),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr), .s_awprot(s_awprot), .s_awworld(s_awworld),
    .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
    .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr), .s_arprot(s_arprot), .s_arworld(s_arworld),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
    .m_psel(m_psel), .m_penable(m_penable), .m_pwrite(m_pwrite), .m_paddr(m_paddr), .m_pwdata(m_pwdata),
    .m_pstrb(m_pstrb), .m_pprot(m_pprot), .m_pnse(m_pnse),
    .m_pready(m_pready), .m_prdata(m_prdata), .m_pslverr(m_pslverr)
  );

  // Same stimulus, no world extension: its m_pnse must stay low.
  apbb_top #(.ADDR_W(AW), .DATA_W(DW), .WORLD_EXT(1'b0)) u_apbb_top_noext (
    .clk(clk), .rst_n(rst_n),
    .s_awvalid(s_awvalid), .s_awready(n_awready), .s_awaddr(s_awaddr), .s_awprot(s_awprot), .s_awworld(s_awworld),
    .s_wvalid(s_wvalid), .s_wready(n_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
    .s_bvalid(n_bvalid), .s_bready(s_bready), .s_bresp(n_bresp),
    .s_arvalid(s_arvalid), .s_arready(n_arready), .s_araddr(s_araddr), .s_arprot(s_arprot), .s_arworld(s_arworld),
    .s_rvalid(n_rvalid), .s_rready(s_rready), .s_rdata(n_rdata), .s_rresp(n_rresp),
    .m_psel(n_psel), .m_penable(n_penable), .m_pwrite(n_pwrite), .m_paddr(n_paddr), .m_pwdata(n_pwdata),
    .m_pstrb(n_pstrb), .m_pprot(n_pprot), .m_pnse(n_pnse),
    .m_pready(m_pready), .m_prdata(m_prdata), .m_pslverr(m_pslverr)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    s_awvalid = 1'b0; s_wvalid = 1'b0; s_arvalid = 1'b0;
    s_bready = 1'b0; s_rready = 1'b0;
    s_awaddr = '0; s_araddr = '0; s_awprot = '0; s_arprot = '0;
    s_awworld = 1'b0; s_arworld = 1'b0; s_wdata = '0; s_wstrb = '0;
    m_pready = 1'b0; m_pslverr = 1'b0; m_prdata = '0;
  endtask

  // Called at the negedge right after the handshake edge (setup cycle).
  task automatic run_apb(input logic wr, input logic [AW-1:0] addr, input logic [2:0] prot,
                         input logic world, input logic [DW-1:0] data, input int waits, input logic err);
    chk(m_psel && !m_penable, "R2 setup phase", {m_psel, m_penable}, 2'b10);
    chk(m_paddr == addr && m_pwrite == wr, "R2 address/direction", {m_pwrite, m_paddr}, {wr, addr});
    chk(m_pprot == prot, "R1 protection routing", m_pprot, prot);
    chk(m_pnse == world, "R8 world bit forwarded", m_pnse, world);
    chk(n_pnse == 1'b0, "R8 world bit low without extension", n_pnse, 1'b0);
    if (wr) chk(m_pwdata == data && m_pstrb == 4'hF, "R2 write data", m_pwdata, data);
    else    chk(m_pstrb == 4'h0, "R2 read strobes", m_pstrb, 4'h0);
    @(negedge clk);
    chk(m_psel && m_penable, "R5 enable one cycle after select", {m_psel, m_penable}, 2'b11);
    for (int i = 0; i < waits; i++) begin
      m_pready = 1'b0;
      @(negedge clk);
      chk(m_psel && m_penable && m_pprot == prot && m_pnse == world && m_paddr == addr,
          "R4 attributes held in wait", {m_penable, m_pnse, m_pprot, m_paddr}, {1'b1, world, prot, addr});
    end
    m_pready = 1'b1; m_pslverr = err; m_prdata = wr ? 32'h5555_AAAA : data;
    @(negedge clk);
    m_pready = 1'b0; m_pslverr = 1'b0; m_prdata = 32'h0;
    chk(!m_psel && !m_penable, "R5 select/enable fall after ready", {m_psel, m_penable}, 2'b00);
    if (wr) begin
      chk(s_bvalid && !s_rvalid, "R7 write response valid", {s_bvalid, s_rvalid}, 2'b10);
      chk(s_bresp == (err ? 2'b10 : 2'b00), "R3 write response code", s_bresp, err ? 2'b10 : 2'b00);
    end else begin
      chk(s_rvalid && !s_bvalid, "R7 read response valid", {s_rvalid, s_bvalid}, 2'b10);
      chk(s_rresp == (err ? 2'b10 : 2'b00), "R3 read response code", s_rresp, err ? 2'b10 : 2'b00);
      chk(s_rdata == data, "R3 read data", s_rdata, data);
    end
    @(negedge clk);
    if (wr) chk(s_bvalid && s_bresp == (err ? 2'b10 : 2'b00), "R7 write response held", {s_bvalid, s_bresp}, {1'b1, err, 1'b0});
    else    chk(s_rvalid && s_rresp == (err ? 2'b10 : 2'b00), "R7 read response held", {s_rvalid, s_rresp}, {1'b1, err, 1'b0});
    if (wr) s_bready = 1'b1; else s_rready = 1'b1;
    @(negedge clk);
    s_bready = 1'b0; s_rready = 1'b0;
    chk(!s_bvalid && !s_rvalid, "R7 response dropped after accept", {s_bvalid, s_rvalid}, 2'b00);
  endtask

  // Issue a lone request from the idle state and run it to completion.
  task automatic issue(input vec_t v);
    if (v.wr) begin
      s_awvalid = 1'b1; s_wvalid = 1'b1; s_awaddr = v.addr; s_awprot = v.prot; s_awworld = v.world;
      s_wdata = v.data; s_wstrb = 4'hF;
      s_arprot = ~v.prot; s_arworld = ~v.world; s_araddr = ~v.addr;
    end else begin
      s_arvalid = 1'b1; s_araddr = v.addr; s_arprot = v.prot; s_arworld = v.world;
      s_awprot = ~v.prot; s_awworld = ~v.world; s_awaddr = ~v.addr;
    end
    #1;
    chk(v.wr ? (s_awready && s_wready && !s_arready) : (s_arready && !s_awready),
        "R6 lone request accepted", {s_arready, s_awready}, v.wr ? 2'b01 : 2'b10);
    @(negedge clk);
    s_awvalid = 1'b0; s_wvalid = 1'b0; s_arvalid = 1'b0;
    s_awaddr = ~s_awaddr; s_araddr = ~s_araddr; s_awprot = ~s_awprot; s_arprot = ~s_arprot;
    s_awworld = ~s_awworld; s_arworld = ~s_arworld; s_wdata = ~s_wdata;
    run_apb(v.wr, v.addr, v.prot, v.world, v.data, int'(v.waits), v.err);
  endtask

  initial begin
    total = 0; bad = 0;
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk(!m_psel && !m_penable && !s_bvalid && !s_rvalid, "R9 reset outputs", {m_psel, m_penable, s_bvalid, s_rvalid}, 4'h0);
    chk(!s_arready && !s_awready && !s_wready, "R9 no ready after reset", {s_arready, s_awready, s_wready}, 3'b000);

    // Vector table
    for (int k = 0; k < NVEC; k++) issue(VECS[k]);

    // R6: write address alone is not accepted
    s_awvalid = 1'b1; s_awaddr = 16'h0100; s_awprot = 3'b001; s_awworld = 1'b1;
    @(negedge clk);
    chk(!s_awready && !s_wready && !m_psel, "R6 write waits for data", {s_awready, m_psel}, 2'b00);
    s_wvalid = 1'b1; s_wdata = 32'hCAFE_0100; s_wstrb = 4'hF;
    #1;
    chk(s_awready && s_wready, "R6 write accepted with data", {s_awready, s_wready}, 2'b11);
    @(negedge clk);
    s_awvalid = 1'b0; s_wvalid = 1'b0;
    run_apb(1'b1, 16'h0100, 3'b001, 1'b1, 32'hCAFE_0100, 1, 1'b0);

    // R6 collision 1: read wins
    s_arvalid = 1'b1; s_araddr = 16'h0A00; s_arprot = 3'b001; s_arworld = 1'b0;
    s_awvalid = 1'b1; s_wvalid = 1'b1; s_awaddr = 16'h0B00; s_awprot = 3'b100; s_awworld = 1'b1;
    s_wdata = 32'h0000_0B0B; s_wstrb = 4'hF;
    #1;
    chk(s_arready && !s_awready, "R6 first collision goes to read", {s_arready, s_awready}, 2'b10);
    @(negedge clk);
    s_arvalid = 1'b0;
    chk(!s_awready, "R6 no accept while busy", s_awready, 1'b0);
    run_apb(1'b0, 16'h0A00, 3'b001, 1'b0, 32'h0A0A_0A0A, 0, 1'b0);
    #1;
    chk(s_awready, "R6 pending write served next", s_awready, 1'b1);
    @(negedge clk);
    s_awvalid = 1'b0; s_wvalid = 1'b0;
    run_apb(1'b1, 16'h0B00, 3'b100, 1'b1, 32'h0000_0B0B, 0, 1'b1);

    // R6 collision 2: write wins
    s_arvalid = 1'b1; s_araddr = 16'h0C00; s_arprot = 3'b110; s_arworld = 1'b1;
    s_awvalid = 1'b1; s_wvalid = 1'b1; s_awaddr = 16'h0D00; s_awprot = 3'b011; s_awworld = 1'b0;
    s_wdata = 32'h0000_0D0D;
    #1;
    chk(s_awready && !s_arready, "R6 second collision goes to write", {s_arready, s_awready}, 2'b01);
    @(negedge clk);
    s_awvalid = 1'b0; s_wvalid = 1'b0;
    run_apb(1'b1, 16'h0D00, 3'b011, 1'b0, 32'h0000_0D0D, 2, 1'b0);
    #1;
    chk(s_arready, "R6 pending read served next", s_arready, 1'b1);
    @(negedge clk);
    s_arvalid = 1'b0;
    run_apb(1'b0, 16'h0C00, 3'b110, 1'b1, 32'h7777_0C0C, 1, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule